// File: doc/BRIEF.md
# Upsampled First-Order Delta-Sigma Tuning Dither

This block sits between the digital loop filter of a bang-bang phase-locked loop and a coarse digitally controlled oscillator. Once per reference cycle the loop filter produces a fixed-point tuning value with more resolution than the oscillator accepts. The block captures that value on a one-cycle strobe and holds it. It then runs a first-order error-feedback delta-sigma modulator on the fast oscillator-output clock, which ticks N times per reference cycle, where N is the feedback division ratio (8 by default).

Every fast cycle the modulator adds the held value to a fractional residue. The integer part of the sum goes out as the tuning word, and the fractional part becomes the new residue. Because the oscillator integrates its period over the N fast cycles of each reference cycle, what the loop sees is the average of those words. That average matches the fractional input exactly over a long enough span. For small fractions, some reference cycles see an average of zero and others a single step.

The input is two's complement with FRAC_W fraction bits, so its value is the raw code divided by 2^FRAC_W (256 by default). The output is a signed integer one bit wider than the integer field of the input.

Top module: `upsampled_dsm`

## Requirements
- R1: While reset is asserted, and after it until the first strobe, the output word is 0 whatever the data input carries.
- R2: A word presented with the strobe is captured at that clock edge. The first output derived from it appears at the next rising edge; the output right after the capture edge still reflects the earlier state.
- R3: While the strobe is low, changes on the data input have no effect; the held word keeps driving the output.
- R4: For a held input value x (code/256), the sum of any M consecutive outputs lies strictly within one output LSB of M·x.
- R5: The fractional residue is not cleared when a new word is captured. Loading 0.75 (code 192) from reset and then 0.25 (code 64) on the next cycle gives outputs 0, 1, 0, 1.
- R6: An input whose fraction bits are all zero yields its integer part on every fast cycle, regardless of the residue.
- R7: The quantizer rounds toward minus infinity. From a zero residue, input −0.25 (code −64) yields −1, 0, 0, 0.
- R8: From a zero residue, input 1/16 (code 16) gives outputs that sum to 0 over the first 8 fast cycles and to 1 over the next 8.
- R9: The output never wraps. Input code 32767 gives 127 and then 128, input code −32768 gives −128 every cycle, and a non-negative held input never gives a negative output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oscillator-output clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | One-cycle strobe marking a new reference-rate value |
| inWord | input | INT_W+FRAC_W | Signed fixed-point tuning value, FRAC_W fraction bits |
| outWord | output | INT_W+1 | Signed integer tuning word, one per fast cycle |

## Verification
The bench builds the block with 8 integer and 8 fraction bits and treats 8 fast cycles as one reference cycle. With these widths, an input of 1/16 makes the residue wrap exactly once every two reference frames, so the zero-then-one frame pattern can be checked exactly. The full-scale codes reach the extra output bit. A table of positive, negative and extreme inputs held for several frames, with no reset between them, exercises the one-LSB bound while the residue carries over from the previous value.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;  // capture the input word this cycle
    logic run;   // advance the modulator this cycle
  } dsmCtl_t;
endpackage

// File: rtl/dsm_ctrl.sv
module dsm_ctrl
  import dsm_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  output dsmCtl_t ctl
);
  logic armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else if (inValid) armed <= 1'b1;
  end

  always_comb begin
    ctl.load = inValid;
    ctl.run  = armed;
  end
endmodule

// File: rtl/dsm_datapath.sv
module dsm_datapath
  import dsm_pkg::*;
#(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dsmCtl_t                   ctl,
  input  logic [INT_W+FRAC_W-1:0]   inWord,
  output logic [INT_W:0]            outWord
);
  localparam int IN_W  = INT_W + FRAC_W;
  localparam int SUM_W = IN_W + 1;

  logic [IN_W-1:0]   heldWord;
  logic [FRAC_W-1:0] errReg;
  logic [INT_W:0]    outReg;
  logic [SUM_W-1:0]  sumWord;

  // held value sign-extended plus non-negative residue
  always_comb begin
    sumWord = {heldWord[IN_W-1], heldWord} + {{(SUM_W-FRAC_W){1'b0}}, errReg};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldWord <= '0;
      errReg   <= '0;
      outReg   <= '0;
    end else begin
      if (ctl.load) heldWord <= inWord;
      if (ctl.run) begin
        outReg <= sumWord[SUM_W-1:FRAC_W];
        errReg <= sumWord[FRAC_W-1:0];
      end
    end
  end

  assign outWord = outReg;
endmodule

// File: rtl/upsampled_dsm.sv
module upsampled_dsm
  import dsm_pkg::*;
#(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic [INT_W+FRAC_W-1:0] inWord,
  output logic [INT_W:0]          outWord
);
  dsmCtl_t ctl;

  dsm_ctrl ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .inValid(inValid),
    .ctl    (ctl)
  );

  dsm_datapath #(.INT_W(INT_W), .FRAC_W(FRAC_W)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .inWord (inWord),
    .outWord(outWord)
  );
endmodule

// File: rtl/upsampled_dsm_chk.sv
module upsampled_dsm_chk #(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 8
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    inValid,
  input logic [INT_W+FRAC_W-1:0] inWord,
  input logic [INT_W:0]          outWord
);
  localparam int IN_W  = INT_W + FRAC_W;
  localparam int OUT_W = INT_W + 1;

  logic              armedChk, prevArmed;
  logic [IN_W-1:0]   capVal, prevCap;
  logic signed [IN_W-1:0] intPrev, outExt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armedChk  <= 1'b0;
      prevArmed <= 1'b0;
      capVal    <= '0;
      prevCap   <= '0;
    end else begin
      if (inValid) begin
        armedChk <= 1'b1;
        capVal   <= inWord;
      end
      prevArmed <= armedChk;
      prevCap   <= capVal;
    end
  end

  always_comb begin
    intPrev = $signed(prevCap) >>> FRAC_W;
    outExt  = $signed({{(IN_W-OUT_W){outWord[OUT_W-1]}}, outWord});
  end

  // R1
  quiet_before_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    !armedChk |-> outWord == '0);

  // R4
  bracket_chk: assert property (@(posedge clk) disable iff (!rstN)
    prevArmed |-> (outExt == intPrev) || (outExt == intPrev + 1));

  // R6
  integer_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (prevArmed && prevCap[FRAC_W-1:0] == '0) |-> outExt == intPrev);

  // R9
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (prevArmed && !prevCap[IN_W-1]) |-> !outWord[OUT_W-1]);
endmodule

bind upsampled_dsm upsampled_dsm_chk #(.INT_W(INT_W), .FRAC_W(FRAC_W)) chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .inValid(inValid),
  .inWord (inWord),
  .outWord(outWord)
);

// File: tb/upsampled_dsm_tb_top.sv
module upsampled_dsm_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int INT_W  = 8;
  localparam int FRAC_W = 8;
  localparam int RATIO  = 8;
  localparam int SCALE  = 1 << FRAC_W;
  localparam int NV     = 6;
  localparam int VEC_IN [NV] = '{64, 300, -1000, 32767, 5, -32768};
  localparam int VEC_K  [NV] = '{1, 2, 3, 1, 4, 2};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [INT_W+FRAC_W-1:0] inWord = '0;
  logic signed [INT_W:0] outWord;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  upsampled_dsm #(.INT_W(INT_W), .FRAC_W(FRAC_W)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inWord(inWord), .outWord(outWord)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    inValid = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // returns at the falling edge right after the capture edge
  task automatic loadWord(input int v);
    inValid = 1'b1;
    inWord = (INT_W+FRAC_W)'(v);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic sumOut(input int m, output int s);
    s = 0;
    for (int i = 0; i < m; i++) begin
      @(negedge clk);
      s += int'(outWord);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int s;
    int diff;
    // R1: reset and quiet until first strobe
    inWord = 16'h1234;
    doReset();
    check(outWord == 0, "R1 reset", int'(outWord), 0);
    repeat (3) @(negedge clk);
    check(outWord == 0, "R1 no strobe yet", int'(outWord), 0);

    // R2 latency, R3 ignore without strobe
    loadWord(768);
    check(outWord == 0, "R2 capture edge", int'(outWord), 0);
    inWord = 16'd999;
    @(negedge clk);
    check(outWord == 3, "R2 first output", int'(outWord), 3);
    repeat (3) @(negedge clk);
    check(outWord == 3, "R3 ignored input", int'(outWord), 3);

    // R4 table with residue carried between entries
    for (int v = 0; v < NV; v++) begin
      loadWord(VEC_IN[v]);
      sumOut(VEC_K[v] * RATIO, s);
      diff = s * SCALE - VEC_K[v] * RATIO * VEC_IN[v];
      check(diff > -SCALE && diff < SCALE, "R4 window sum", s * SCALE, VEC_K[v] * RATIO * VEC_IN[v]);
    end

    // R5 residue carry across a new load
    doReset();
    loadWord(192);
    @(negedge clk);
    check(outWord == 0, "R5 step0", int'(outWord), 0);
    inValid = 1'b1;
    inWord = 16'd64;
    @(negedge clk);
    inValid = 1'b0;
    check(outWord == 1, "R5 step1", int'(outWord), 1);
    @(negedge clk);
    check(outWord == 0, "R5 step2", int'(outWord), 0);
    @(negedge clk);
    check(outWord == 1, "R5 carried residue", int'(outWord), 1);

    // R6 integer input with nonzero residue
    loadWord(1280);
    for (int i = 0; i < RATIO; i++) begin
      @(negedge clk);
      check(outWord == 5, "R6 integer", int'(outWord), 5);
    end

    // R7 negative floor
    doReset();
    loadWord(-64);
    @(negedge clk);
    check(outWord == -1, "R7 first", int'(outWord), -1);
    sumOut(3, s);
    check(s == 0, "R7 rest", s, 0);

    // R8 small fraction across two frames
    doReset();
    loadWord(16);
    sumOut(RATIO, s);
    check(s == 0, "R8 frame0", s, 0);
    sumOut(RATIO, s);
    check(s == 1, "R8 frame1", s, 1);

    // R9 extremes
    doReset();
    loadWord(32767);
    @(negedge clk);
    check(outWord == 127, "R9 max first", int'(outWord), 127);
    @(negedge clk);
    check(outWord == 128, "R9 max second", int'(outWord), 128);
    loadWord(-32768);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(outWord == -128, "R9 min", int'(outWord), -128);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule